// File: doc/BRIEF.md
# Two-Stage SPI Serial-Clock Prescaler

This block turns a fast reference clock into the timing pulses an SPI master needs to drive its serial clock. It divides in two stages. A linear stage divides by a 4-bit setting plus one. A binary stage then divides by two raised to a second 4-bit setting. One serial-clock period therefore lasts (pre + 1) × 2^post reference cycles, for any ratio from 1 up to 16 × 32768.

The block gives the shifter a single-cycle pulse at each half-period boundary. The shifter toggles its serial clock on that pulse. The block also gives a phase level that runs at the serial-clock rate: it is low in the first half of each period and high in the second.

Counting only happens while both the enable and the run input are high. If either one drops, both counters clear, so the next burst starts on a fresh, whole period. The two divider settings are captured together. While idle they are captured every cycle. While running they are captured only at the end of a full period, so a change in the middle of a period never bends that period.

Top module: `spi_sclk_prescaler`

## Requirements
- R1: While reset is asserted, and after release with enable and run low, `sclk_tick` and `sclk_phase` are both 0.
- R2: While enable and run are both high, the full serial-clock period is P = (pre_div + 1) × 2^post_div reference cycles. Counting from the first active cycle as position 0, an end-of-period tick appears at position P − 1 and then every P cycles.
- R3: With post_div = 0, the pre_div field alone sets the ratio, pre_div + 1, over the range 1 to 16.
- R4: With pre_div = 0, the post_div field alone sets the ratio, 2^post_div, with exponents 0 to 15.
- R5: When P ≥ 2, a second tick appears in each period at position floor(P/2) − 1. When P = 1, this second tick does not appear.
- R6: `sclk_phase` inverts on the clock edge that ends every cycle in which `sclk_tick` is 1. In every other active cycle it holds its value. Each burst therefore starts with the phase low.
- R7: If enable or run is low for a cycle, the following edge clears both counters and the phase. `sclk_tick` is 0 during any cycle with enable or run low. The next active cycle is position 0 of a new period.
- R8: When P = 1 (pre_div = 0 and post_div = 0), `sclk_tick` is 1 in every active cycle and `sclk_phase` inverts every cycle.
- R9: A change to pre_div or post_div during a burst does not alter the period in progress. Both fields take effect together from the next period boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable; low holds the dividers cleared |
| run | input | 1 | Burst in progress; low holds the dividers cleared |
| pre_div | input | 4 | Linear stage setting; that stage divides by this value plus one |
| post_div | input | 4 | Binary stage exponent; that stage divides by two to this power |
| sclk_tick | output | 1 | One-cycle pulse at each half-period boundary of the serial clock |
| sclk_phase | output | 1 | Serial-clock-rate level: low in the first half of a period, high in the second |

## Verification
The bench runs each stage on its own first. It sweeps pre_div with the exponent at zero, then post_div with the linear ratio at one. This separates a fault in the linear count from a fault in the power-of-two count. Mixed settings, including one with a 32768-cycle period, show whether the two stages multiply and whether the midpoint tick lands at the exact half of an even period and at the floor of an odd one. Dropping run and then enable in mid-period, changing both fields in mid-period, and the unity ratio separate the restart, deferred-update and every-cycle behaviours from ordinary counting.

// File: rtl/spi_presc_pkg.sv
package spi_presc_pkg;
  localparam int PRE_W_DEF  = 4;
  localparam int POST_W_DEF = 4;

  // Bits needed by the binary stage counter for a given exponent field width.
  function automatic int bin_cnt_bits(input int exp_w);
    return (1 << exp_w) - 1;
  endfunction
endpackage

// File: rtl/presc_linear.sv
module presc_linear #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] lim,
  output logic         last,
  output logic         mid
);
  logic [W-1:0] cnt_q, cnt_d;
  logic [W:0]   half_pt;

  assign half_pt = ({1'b0, lim} + {{W{1'b0}}, 1'b1}) >> 1;
  assign last    = (cnt_q == lim);
  assign mid     = (lim != '0) && ({1'b0, cnt_q} == (half_pt - {{W{1'b0}}, 1'b1}));

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (last) cnt_d = '0;
    else           cnt_d = cnt_q + {{(W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3
  lin_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim);

  // R7
  lin_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/presc_binary.sv
module presc_binary #(
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [EXP_W-1:0] exp_sel,
  output logic             last,
  output logic             mid
);
  localparam int CW = spi_presc_pkg::bin_cnt_bits(EXP_W);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW:0]   span;
  logic [CW:0]   cnt_x;

  assign span  = {{CW{1'b0}}, 1'b1} << exp_sel;
  assign cnt_x = {1'b0, cnt_q};
  assign last  = (cnt_x == (span - {{CW{1'b0}}, 1'b1}));
  assign mid   = (exp_sel != '0) && (cnt_x == ((span >> 1) - {{CW{1'b0}}, 1'b1}));

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (step) cnt_d = last ? '0 : cnt_q + {{(CW-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4
  bin_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_x < span);

  // R2
  bin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !step) |=> $stable(cnt_q));
endmodule

// File: rtl/presc_phase.sv
module presc_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic phase
);
  logic ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    if (clr)       ph_d = 1'b0;
    else if (tick) ph_d = ~ph_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ph_d;
  end

  assign phase = ph_q;

  // R6
  phase_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr) |=> (phase != $past(phase)));

  // R6
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(phase));

  // R7
  phase_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !phase);
endmodule

// File: rtl/spi_sclk_prescaler.sv
module spi_sclk_prescaler #(
  parameter int PRE_W  = spi_presc_pkg::PRE_W_DEF,
  parameter int POST_W = spi_presc_pkg::POST_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              run,
  input  logic [PRE_W-1:0]  pre_div,
  input  logic [POST_W-1:0] post_div,
  output logic              sclk_tick,
  output logic              sclk_phase
);
  logic              active, idle;
  logic [PRE_W-1:0]  pre_q, pre_d;
  logic [POST_W-1:0] post_q, post_d;
  logic              cfg_load;
  logic              lin_last, lin_mid, bin_last, bin_mid;
  logic              end_tick, mid_tick;

  assign active = en & run;
  assign idle   = ~active;

  presc_linear #(.W(PRE_W)) u_lin (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (idle),
    .lim  (pre_q),
    .last (lin_last),
    .mid  (lin_mid)
  );

  presc_binary #(.EXP_W(POST_W)) u_bin (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (idle),
    .step   (lin_last),
    .exp_sel(post_q),
    .last   (bin_last),
    .mid    (bin_mid)
  );

  assign end_tick  = active & lin_last & bin_last;
  assign mid_tick  = active & ((post_q == '0) ? lin_mid : (lin_last & bin_mid));
  assign sclk_tick = end_tick | mid_tick;

  presc_phase u_ph (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (idle),
    .tick (sclk_tick),
    .phase(sclk_phase)
  );

  // Divider fields are captured together: every idle cycle, and at period end.
  assign cfg_load = idle | end_tick;

  always_comb begin
    pre_d  = pre_q;
    post_d = post_q;
    if (cfg_load) begin
      pre_d  = pre_div;
      post_d = post_div;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      post_q <= '0;
    end else begin
      pre_q  <= pre_d;
      post_q <= post_d;
    end
  end

  // R8
  unity_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && pre_q == '0 && post_q == '0) |-> sclk_tick);

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !end_tick) |=> ($stable(pre_q) && $stable(post_q)));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sclk_tick);
endmodule

// File: tb/spi_sclk_prescaler_test.sv
`timescale 1ns/1ps
module spi_sclk_prescaler_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en, run;
  logic [3:0] pre_div, post_div;
  logic       sclk_tick, sclk_phase;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  // bench-side reference state
  int m_pos = 0;
  int m_p   = 1;
  bit m_ph  = 1'b0;

  always #2.5 clk = ~clk;

  spi_sclk_prescaler uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .run       (run),
    .pre_div   (pre_div),
    .post_div  (post_div),
    .sclk_tick (sclk_tick),
    .sclk_phase(sclk_phase)
  );

  function automatic int ratio(input logic [3:0] p, input logic [3:0] q);
    return (int'(p) + 1) << q;
  endfunction

  // Drive one cycle's inputs, check outputs of that cycle, advance reference.
  task automatic cyc(input logic e, input logic r, input logic [3:0] pv,
                     input logic [3:0] qv, input string req);
    bit act, exp_tick;
    @(negedge clk);
    en = e; run = r; pre_div = pv; post_div = qv;
    #1;
    act      = e & r;
    exp_tick = act && ((m_pos == m_p - 1) || (m_p >= 2 && m_pos == m_p / 2 - 1));
    checks++;
    if (sclk_tick !== exp_tick || sclk_phase !== m_ph) begin
      errors++;
      $display("FAIL %s: pos=%0d period=%0d tick=%b phase=%b expected tick=%b phase=%b",
               req, m_pos, m_p, sclk_tick, sclk_phase, exp_tick, m_ph);
    end
    if (!act) begin
      m_pos = 0; m_ph = 1'b0; m_p = ratio(pv, qv);
    end else begin
      if (exp_tick) m_ph = ~m_ph;
      if (m_pos == m_p - 1) begin
        m_pos = 0; m_p = ratio(pv, qv);
      end else begin
        m_pos++;
      end
    end
  endtask

  task automatic burst(input logic [3:0] pv, input logic [3:0] qv, input int n,
                       input string req);
    cyc(1'b1, 1'b0, pv, qv, req);
    cyc(1'b1, 1'b0, pv, qv, req);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b1, pv, qv, req);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; en = 1'b0; run = 1'b0; pre_div = 4'd3; post_div = 4'd2;
    repeat (3) @(negedge clk);
    checks++;
    if (sclk_tick !== 1'b0 || sclk_phase !== 1'b0) begin
      errors++;
      $display("FAIL R1: tick=%b phase=%b expected tick=0 phase=0", sclk_tick, sclk_phase);
    end
    rst_n = 1'b1;
    m_pos = 0; m_ph = 1'b0; m_p = 1;
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 4'd3, 4'd2, "R1");
  endtask

  task automatic t_linear;
    burst(4'd1,  4'd0, 7,  "R3");
    burst(4'd2,  4'd0, 10, "R3 R5");
    burst(4'd5,  4'd0, 15, "R3 R5");
    burst(4'd15, 4'd0, 40, "R3");
  endtask

  task automatic t_binary;
    burst(4'd0, 4'd1, 7,   "R4");
    burst(4'd0, 4'd3, 20,  "R4 R5");
    burst(4'd0, 4'd6, 140, "R4");
  endtask

  task automatic t_mixed;
    burst(4'd2,  4'd2, 30,    "R2 R5 R6");
    burst(4'd15, 4'd4, 520,   "R2 R5 R6");
    burst(4'd7,  4'd12, 32772, "R2 R5");
  endtask

  task automatic t_restart;
    burst(4'd3, 4'd1, 5, "R7");
    cyc(1'b1, 1'b0, 4'd3, 4'd1, "R7");
    for (int i = 0; i < 12; i++) cyc(1'b1, 1'b1, 4'd3, 4'd1, "R7");
    cyc(1'b0, 1'b1, 4'd3, 4'd1, "R7");
    for (int i = 0; i < 12; i++) cyc(1'b1, 1'b1, 4'd3, 4'd1, "R7");
  endtask

  task automatic t_unity;
    burst(4'd0, 4'd0, 9, "R8");
  endtask

  task automatic t_change;
    burst(4'd1, 4'd2, 3, "R9");
    for (int i = 0; i < 14; i++) cyc(1'b1, 1'b1, 4'd0, 4'd1, "R9");
    for (int i = 0; i < 20; i++) cyc(1'b1, 1'b1, 4'd4, 4'd0, "R9");
  endtask

  initial begin
    t_reset();
    t_linear();
    t_binary();
    t_mixed();
    t_restart();
    t_unity();
    t_change();
    cyc(1'b0, 1'b0, 4'd0, 4'd0, "R7");
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule